// File: doc/BRIEF.md
# SPI Interrupt Flag Register

This block keeps the interrupt status byte of an SPI peripheral that can run as bus host or as client. Five flags live in the byte, each with its own set event and its own way of being cleared: some are cleared by writing a one over the register bus, some by a side effect of a data register access, and some by a receiver disable. The serial shifter, the data buffers and the other status registers stay outside. They report what happens through one-cycle event strobes. The select pin arrives asynchronously and passes through a synchroniser before its edges are used.

A small transaction tracker follows each client transaction. It is a state machine with the states `TRK_IDLE` (select high), `TRK_WAIT_ADDR` (select low, no word received yet), `TRK_HIT` (first word matched the address) and `TRK_MISS` (first word did not match). The transitions are: `TRK_IDLE` to `TRK_WAIT_ADDR` on a select falling edge. `TRK_WAIT_ADDR` goes to `TRK_HIT` or `TRK_MISS` on the first received word, depending on the address comparison. Any state returns to `TRK_IDLE` on a select rising edge. The end-of-transaction decision is taken from the state held before that return. A second byte register holds per-flag interrupt enables. The interrupt request is the registered OR of the enabled flags.

Top module: `spi_irq_flags`

## Requirements
- R1: After reset the flag byte is 0x00. The bit positions are error = bit 7, select-low = bit 3, receive-complete = bit 2, transmit-complete = bit 1 and data-empty = bit 0. Bits 6..4 always read 0.
- R2: The error flag (bit 7) is set by `err_ovf` or `err_len`. A flag-register write with bit 7 = 1 clears it, and a write with bit 7 = 0 leaves it unchanged.
- R3: The select-low flag (bit 3) is set on a falling edge of the synchronised `ss_level` only when `host_mode`=0 and `sel_low_det_en`=1. A flag-register write with bit 3 = 1 clears it.
- R4: The receive-complete flag (bit 2) is set by `rx_word` and cleared by `dat_rd` or `rx_disable`. Flag-register writes never change it.
- R5: With `host_mode`=1, `shift_done` sets the transmit-complete flag (bit 1) only when `tx_pending`=0.
- R6: With `host_mode`=0, a rising edge of the synchronised `ss_level` sets bit 1. If `addr_match_en`=1, this happens only when the first `rx_word` of that transaction came with `addr_hit`=1.
- R7: The transmit-complete flag is cleared by a flag-register write with bit 1 = 1 or by `dat_wr`.
- R8: The data-empty flag (bit 0) is set by `tx_moved` and cleared by `dat_wr`. Flag-register writes never change it.
- R9: When a set event and a clear request for the same flag occur in the same cycle, the flag ends up set.
- R10: `irq` equals, one cycle later, the OR of (flag byte AND enable byte). The enable byte is written and read back with `reg_sel`=1. The flag byte is read with `reg_sel`=0.
- R11: The select pin passes through `SYNC_STAGES` flip-flops before edge detection. An edge on `ss_level` affects the flags on the clock edge after it has passed through all stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_mode | input | 1 | 1 = host, 0 = client |
| sel_low_det_en | input | 1 | Enables select-low detection in client mode |
| addr_match_en | input | 1 | Gates client transmit-complete by the address match |
| ss_level | input | 1 | Asynchronous select pin level (idle high) |
| shift_done | input | 1 | Host: a word finished shifting out |
| tx_pending | input | 1 | New transmit data is waiting in the data register |
| tx_moved | input | 1 | Data register content moved to the shifter, now empty |
| dat_wr | input | 1 | Data register written |
| dat_rd | input | 1 | Data register read |
| rx_word | input | 1 | A word entered the receive buffer |
| addr_hit | input | 1 | The word flagged by `rx_word` matches the address |
| rx_disable | input | 1 | Receiver being disabled |
| err_ovf | input | 1 | Buffer overflow detected |
| err_len | input | 1 | Length error detected |
| reg_sel | input | 1 | 0 = flag register, 1 = enable register |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| flags | output | 8 | Flag byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that every event input is a single-cycle strobe and that `addr_hit` is only meaningful alongside `rx_word`. They also assume the mode and enable bits do not change while the select pin is low, and that the select pin holds each level for longer than the synchroniser depth. The stimulus drives all strobes for exactly one clock, changes mode bits only while select is high, and holds each select level for at least four cycles before it looks at the flags.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
    localparam int FLAG_W   = 8;
    localparam int B_ERR    = 7;
    localparam int B_SSL    = 3;
    localparam int B_RXC    = 2;
    localparam int B_TXC    = 1;
    localparam int B_DRE    = 0;
    localparam logic [FLAG_W-1:0] W1C_MASK =
        (FLAG_W'(1) << B_ERR) | (FLAG_W'(1) << B_SSL) | (FLAG_W'(1) << B_TXC);

    typedef enum logic [1:0] {
        TRK_IDLE      = 2'd0,
        TRK_WAIT_ADDR = 2'd1,
        TRK_HIT       = 2'd2,
        TRK_MISS      = 2'd3
    } trk_state_t;
endpackage

// File: rtl/spi_ss_edge.sv
module spi_ss_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_async,
    output logic ss_fall,
    output logic ss_rise
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   last_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= ss_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain[SYNC_STAGES-1];
    end

    always_comb begin
        ss_fall = last_q & ~chain[SYNC_STAGES-1];
        ss_rise = ~last_q & chain[SYNC_STAGES-1];
    end

    // R11: edges are exclusive
    p_edges_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ss_fall && ss_rise));
endmodule

// File: rtl/spi_xfer_track.sv
module spi_xfer_track
    import spi_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_mode,
    input  logic addr_match_en,
    input  logic ss_fall,
    input  logic ss_rise,
    input  logic rx_word,
    input  logic addr_hit,
    output logic client_done
);
    trk_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE: begin
                if (ss_fall) state_d = TRK_WAIT_ADDR;
            end
            TRK_WAIT_ADDR: begin
                if (ss_rise)      state_d = TRK_IDLE;
                else if (rx_word) state_d = addr_hit ? TRK_HIT : TRK_MISS;
            end
            TRK_HIT, TRK_MISS: begin
                if (ss_rise) state_d = TRK_IDLE;
            end
            default: state_d = TRK_IDLE;
        endcase
    end

    always_comb begin
        client_done = ss_rise && !host_mode &&
                      (!addr_match_en || state_q == TRK_HIT);
    end

    // R6: a rising select always ends the transaction
    p_rise_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ss_rise |=> state_q == TRK_IDLE);
    // R6: gated completion requires a matched first word
    p_gate_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (client_done && addr_match_en) |-> state_q == TRK_HIT);
endmodule

// File: rtl/spi_flag_bits.sv
module spi_flag_bits
    import spi_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_mode,
    input  logic              sel_low_det_en,
    input  logic              ss_fall,
    input  logic              client_done,
    input  logic              shift_done,
    input  logic              tx_pending,
    input  logic              tx_moved,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic              rx_word,
    input  logic              rx_disable,
    input  logic              err_ovf,
    input  logic              err_len,
    input  logic              w1c_stb,
    input  logic [FLAG_W-1:0] w1c_data,
    output logic [FLAG_W-1:0] flags_q
);
    logic [FLAG_W-1:0] set_vec, clr_vec, flags_d;

    always_comb begin
        set_vec        = '0;
        set_vec[B_ERR] = err_ovf | err_len;
        set_vec[B_SSL] = ss_fall & ~host_mode & sel_low_det_en;
        set_vec[B_RXC] = rx_word;
        set_vec[B_TXC] = (host_mode & shift_done & ~tx_pending) | client_done;
        set_vec[B_DRE] = tx_moved;

        clr_vec        = w1c_stb ? (w1c_data & W1C_MASK) : '0;
        clr_vec[B_RXC] = dat_rd | rx_disable;
        clr_vec[B_TXC] = clr_vec[B_TXC] | dat_wr;
        clr_vec[B_DRE] = dat_wr;

        flags_d = set_vec | (flags_q & ~clr_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[6:4] == 3'b000);
    p_err_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovf || err_len) |=> flags_q[B_ERR]);
    p_ssl_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[B_SSL]) |-> $past(ss_fall && !host_mode && sel_low_det_en));
    p_rxc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((dat_rd || rx_disable) && !rx_word) |=> !flags_q[B_RXC]);
    p_txc_host_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode && shift_done && !tx_pending) |=> flags_q[B_TXC]);
    p_dre_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !tx_moved) |=> !flags_q[B_DRE]);
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word && dat_rd) |=> flags_q[B_RXC]);
endmodule

// File: rtl/spi_irq_flags.sv
module spi_irq_flags
    import spi_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_mode,
    input  logic       sel_low_det_en,
    input  logic       addr_match_en,
    input  logic       ss_level,
    input  logic       shift_done,
    input  logic       tx_pending,
    input  logic       tx_moved,
    input  logic       dat_wr,
    input  logic       dat_rd,
    input  logic       rx_word,
    input  logic       addr_hit,
    input  logic       rx_disable,
    input  logic       err_ovf,
    input  logic       err_len,
    input  logic       reg_sel,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [7:0] flags,
    output logic       irq
);
    logic              ss_fall, ss_rise, client_done;
    logic [FLAG_W-1:0] flag_q, ien_q;
    logic              irq_q;

    spi_ss_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ss_async (ss_level),
        .ss_fall  (ss_fall),
        .ss_rise  (ss_rise)
    );

    spi_xfer_track u_trk (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_mode     (host_mode),
        .addr_match_en (addr_match_en),
        .ss_fall       (ss_fall),
        .ss_rise       (ss_rise),
        .rx_word       (rx_word),
        .addr_hit      (addr_hit),
        .client_done   (client_done)
    );

    spi_flag_bits u_bits (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_mode      (host_mode),
        .sel_low_det_en (sel_low_det_en),
        .ss_fall        (ss_fall),
        .client_done    (client_done),
        .shift_done     (shift_done),
        .tx_pending     (tx_pending),
        .tx_moved       (tx_moved),
        .dat_wr         (dat_wr),
        .dat_rd         (dat_rd),
        .rx_word        (rx_word),
        .rx_disable     (rx_disable),
        .err_ovf        (err_ovf),
        .err_len        (err_len),
        .w1c_stb        (reg_wr && !reg_sel),
        .w1c_data       (reg_wdata),
        .flags_q        (flag_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (reg_wr && reg_sel) ien_q <= reg_wdata;
            irq_q <= |(flag_q & ien_q);
        end
    end

    always_comb begin
        flags     = flag_q;
        irq       = irq_q;
        reg_rdata = reg_sel ? ien_q : flag_q;
    end

    p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 8'h00) |=> !irq);
endmodule

// File: tb/sim_spi_irq_flags.sv
module sim_spi_irq_flags;
    logic clk = 0, rst_n = 0;
    logic host_mode = 1, sel_low_det_en = 0, addr_match_en = 0, ss_level = 1;
    logic shift_done = 0, tx_pending = 0, tx_moved = 0, dat_wr = 0, dat_rd = 0;
    logic rx_word = 0, addr_hit = 0, rx_disable = 0, err_ovf = 0, err_len = 0;
    logic reg_sel = 0, reg_wr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata, flags;
    logic irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_irq_flags u0 (.*);

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic nclk(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic end_stb;
        {shift_done, tx_moved, dat_wr, dat_rd, rx_word, addr_hit} = '0;
        {rx_disable, err_ovf, err_len, reg_wr} = '0;
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        @(negedge clk); reg_sel = sel; reg_wr = 1; reg_wdata = d;
        @(negedge clk); end_stb(); reg_sel = 0;
    endtask

    task automatic set_host_flags; // sets bits 7,2,1,0
        @(negedge clk); host_mode = 1; tx_pending = 0;
        err_ovf = 1; rx_word = 1; tx_moved = 1; shift_done = 1;
        @(negedge clk); end_stb();
    endtask

    task automatic clear_all;
        @(negedge clk); dat_wr = 1; dat_rd = 1; reg_wr = 1; reg_sel = 0; reg_wdata = 8'hFF;
        @(negedge clk); end_stb();
    endtask

    task automatic ss_go(logic v);
        @(negedge clk); ss_level = v; nclk(4);
    endtask

    initial begin
        nclk(3); rst_n = 1; @(negedge clk);
        chk("R1 reset flags", flags, 8'h00);
        chk("R10 reset irq", {7'b0, irq}, 8'h00);

        // R2 ERROR from each source
        @(negedge clk); err_len = 1; @(negedge clk); end_stb();
        chk("R2 err_len sets", flags, 8'h80);
        wr(0, 8'h7F); chk("R2 write 0 keeps", flags, 8'h80);
        wr(0, 8'h80); chk("R2 write 1 clears", flags, 8'h00);

        // R2/R7/R4/R8/R1: sweep all write values against flags 0x87
        for (int v = 0; v < 256; v++) begin
            set_host_flags();
            wr(0, v[7:0]);
            chk("R1 R2 R4 R7 R8 w1c sweep", flags, 8'h87 & ~(v[7:0] & 8'h82));
            clear_all();
        end

        // R5 host TXC gated by tx_pending
        @(negedge clk); host_mode = 1; tx_pending = 1; shift_done = 1;
        @(negedge clk); end_stb(); tx_pending = 0;
        chk("R5 pending blocks TXC", flags, 8'h00);
        @(negedge clk); shift_done = 1; @(negedge clk); end_stb();
        chk("R5 shift done sets TXC", flags, 8'h02);
        @(negedge clk); dat_wr = 1; @(negedge clk); end_stb();
        chk("R7 data write clears TXC", flags, 8'h00);

        // R4 RXC cleared by rx_disable
        @(negedge clk); rx_word = 1; @(negedge clk); end_stb();
        chk("R4 rx word sets", flags, 8'h04);
        @(negedge clk); rx_disable = 1; @(negedge clk); end_stb();
        chk("R4 rx disable clears", flags, 8'h00);

        // R8 DRE
        @(negedge clk); tx_moved = 1; @(negedge clk); end_stb();
        chk("R8 moved sets DRE", flags, 8'h01);
        @(negedge clk); dat_wr = 1; @(negedge clk); end_stb();
        chk("R8 data write clears DRE", flags, 8'h00);

        // R9 set wins
        @(negedge clk); rx_word = 1; dat_rd = 1; tx_moved = 1; dat_wr = 1;
        err_ovf = 1; reg_wr = 1; reg_wdata = 8'h80;
        @(negedge clk); end_stb();
        chk("R9 set beats clear", flags, 8'h85);
        clear_all();

        // R3 SSL: every combination of host_mode and enable
        for (int m = 0; m < 4; m++) begin
            host_mode = m[1]; sel_low_det_en = m[0];
            ss_go(0);
            chk("R3 R11 SSL on fall", flags, (m == 1) ? 8'h08 : 8'h00);
            ss_go(1); clear_all();
        end

        // R11: SSL appears only after the sync stages
        host_mode = 0; sel_low_det_en = 1;
        @(negedge clk); ss_level = 0;
        @(negedge clk); chk("R11 not yet after 1 edge", flags, 8'h00);
        @(negedge clk); chk("R11 not yet after 2 edges", flags, 8'h00);
        @(negedge clk); chk("R11 set after 3 edges", flags, 8'h08);
        wr(0, 8'h08); chk("R3 write 1 clears SSL", flags, 8'h00);
        ss_go(1); clear_all(); sel_low_det_en = 0;

        // R6 client TXC: addr enable x match
        for (int c = 0; c < 4; c++) begin
            host_mode = 0; addr_match_en = c[1];
            ss_go(0);
            @(negedge clk); rx_word = 1; addr_hit = c[0];
            @(negedge clk); end_stb();
            @(negedge clk); rx_word = 1; addr_hit = 1;  // later word must not count
            @(negedge clk); end_stb();
            ss_go(1);
            chk("R6 client TXC on rise", flags & 8'h02,
                (c[1] && !c[0]) ? 8'h00 : 8'h02);
            clear_all();
        end
        addr_match_en = 0; host_mode = 1;

        // R10 irq sweep over all enable values with flags 0x87
        set_host_flags();
        for (int v = 0; v < 256; v++) begin
            wr(1, v[7:0]);
            @(negedge clk);
            chk("R10 irq sweep", {7'b0, irq}, {7'b0, |(v[7:0] & 8'h87)});
            reg_sel = 1; #1;
            chk("R10 enable readback", reg_rdata, v[7:0]);
            reg_sel = 0; #1;
            chk("R10 flag readback", reg_rdata, 8'h87);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule